// File: doc/BRIEF.md
# Power Mode Wake-Up Controller

This block sequences the power state of a small embedded system among four levels: Fullspeed, Standby, Suspend and Hibernate. It runs on an always-on clock. Its asynchronous reset `rst_ni` belongs to the always-on (real-time-clock) domain. Software asks for a lower-power level through a four-word register interface. Once a short entry window has passed, the block commits to that level. It then drives enables for the core clock, core power, core reset and DRAM self-refresh. The actual clock gating, regulators and refresh logic sit outside the block.

The block watches twenty wake sources, each with its own enable bit. They are a modem carrier-detect pin (active low), a power button, a real-time-clock alarm, a removable-card interrupt-request pin (active low) and sixteen general-purpose inputs. Each source passes through a two-flop synchronizer and is detected on its active edge. An enabled edge during a low-power level, or during entry into one, brings the system back to Fullspeed and sets a sticky cause bit. Leaving Hibernate goes through a power-up phase. In that phase core power is enabled and core reset is held for a programmable number of cycles. The same power-up phase follows every always-on reset, so the system always comes up at Fullspeed with no wake event needed.

Register map (address on `reg_addr_i`):
- 0: read gives the current mode in bits [1:0]; a write requests a mode from bits [1:0].
- 1: wake enables.
- 2: wake causes; writing 1 clears a bit.
- 3: stabilization count.

Enable and cause bits share one layout:
- bit 0: carrier detect
- bit 1: power button
- bit 2: alarm
- bit 3: card request
- bit 4+i: general-purpose input i

Top module: `pwr_wake_ctrl`

## Requirements
- R1: While `rst_ni` is low, and for the first 8 clock edges after it rises (the reset value of the stabilization count), mode_o reads 2'b11, core_pwr_en_o is 1 and core_rst_no is 0. On the 8th edge mode_o becomes 2'b00 and core_rst_no becomes 1, with no wake event needed. After reset the enable and cause registers read 0 and register 3 reads 8.
- R2: Mode encoding is 00 Fullspeed, 01 Standby, 10 Suspend, 11 Hibernate. A write of 01, 10 or 11 to address 0 while in Fullspeed starts entry. mode_o reports 00 for the first 3 clock edges after the write edge and reports the requested mode from the 4th edge on.
- R3: A mode write is ignored when it is made outside Fullspeed. A write of 00 in Fullspeed has no effect.
- R4: Outputs {core_clk_en_o, core_pwr_en_o, core_rst_no, dram_sr_o} are:
  - 1110 in Fullspeed
  - 0110 in Standby
  - 0111 in Suspend
  - 0001 in Hibernate
- R5: Active edges are falling on `carrier_ni` and `card_irq_ni`, and rising on `pwr_btn_i`, `rtc_alarm_i` and each `gpio_i` bit. An enabled active edge applied before a clock edge acts on the 3rd clock edge after it. A wake always ends at mode 00, never at an intermediate mode.
- R6: An edge on a source whose enable bit is 0 neither wakes the block nor sets its cause bit.
- R7: A wake from Standby or Suspend reports 00 on the same edge that accepts it. A wake from Hibernate behaves as follows, with N the count in register 3:
  - On the edge that accepts it, core_pwr_en_o becomes 1, core_rst_no stays 0 and mode_o stays 11.
  - After N further edges, mode_o becomes 00.
- R8: Cause bits are sticky. A write of 1 to a bit at address 2 clears only that bit. Edges seen in Fullspeed are not recorded.
- R9: An enabled wake edge accepted during the entry window aborts the entry. The block stays in Fullspeed with core clock enabled, and the cause bit is recorded.
- R10: A source held at its active level is not a wake event. Only a new active edge during a low-power mode wakes the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Always-on domain reset, active low, asynchronous |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | DATA_W (20) | Register write data |
| reg_rdata_o | output | DATA_W (20) | Register read data (combinational) |
| carrier_ni | input | 1 | Modem carrier detect, active low |
| pwr_btn_i | input | 1 | Power button, active high |
| rtc_alarm_i | input | 1 | Real-time-clock alarm, active high |
| gpio_i | input | NGPIO (16) | General-purpose wake inputs, active high |
| card_irq_ni | input | 1 | Removable-card interrupt request, active low |
| mode_o | output | 2 | Current power mode |
| core_pwr_en_o | output | 1 | Core-domain power enable |
| core_rst_no | output | 1 | Core-domain reset, active low |
| core_clk_en_o | output | 1 | Core clock enable |
| dram_sr_o | output | 1 | DRAM self-refresh request |

## Verification
The assertions assume the following about the inputs:
- Each wake input is either a level or a change that lasts at least three clock cycles, so the synchronized sample always reflects the change.
- Register writes are single-cycle strobes with a stable address and data.

The stimulus keeps to these rules by changing inputs only at falling clock edges. It holds each source at its active level for at least three cycles before releasing it, and waits again before the next event. This keeps one event from ever merging into the next.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;
  typedef enum logic [1:0] {
    MODE_FULL = 2'b00,
    MODE_STBY = 2'b01,
    MODE_SUSP = 2'b10,
    MODE_HIB  = 2'b11
  } pmode_e;

  typedef enum logic [1:0] {
    ST_RUN, ST_ENTER, ST_LOW, ST_PWRUP
  } pstate_e;

  localparam logic [1:0] ADDR_MODE  = 2'd0;
  localparam logic [1:0] ADDR_WEN   = 2'd1;
  localparam logic [1:0] ADDR_CAUSE = 2'd2;
  localparam logic [1:0] ADDR_STAB  = 2'd3;

  localparam int NFIXED = 4;  // carrier, button, alarm, card
endpackage

// File: rtl/pwr_wake_sync.sv
module pwr_wake_sync #(
  parameter int N = 20
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] act_i,   // normalized active-high
  output logic [N-1:0] edge_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic s1_q, s2_q, s3_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
        s3_q <= 1'b0;
      end else begin
        s1_q <= act_i[g];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign edge_o[g] = s2_q & ~s3_q;
  end

  assert_edge_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_o & $past(edge_o)) == '0);
endmodule

// File: rtl/pwr_wake_regs.sv
module pwr_wake_regs
  import pwr_wake_pkg::*;
#(
  parameter int NSRC     = 20,
  parameter int STAB_W   = 16,
  parameter int STAB_RST = 8,
  parameter int DATA_W   = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NSRC-1:0]   edge_i,
  input  logic              rec_en_i,
  input  logic [1:0]        mode_i,
  output logic [NSRC-1:0]   wake_en_o,
  output logic [STAB_W-1:0] stab_o,
  output logic              mode_wr_o,
  output logic [1:0]        mode_req_o
);
  logic [NSRC-1:0]   wen_q, cause_q, clr_vec, set_vec;
  logic [STAB_W-1:0] stab_q;

  assign clr_vec = (we_i && addr_i == ADDR_CAUSE) ? wdata_i[NSRC-1:0] : '0;
  assign set_vec = edge_i & wen_q & {NSRC{rec_en_i}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wen_q   <= '0;
      cause_q <= '0;
      stab_q  <= STAB_W'(STAB_RST);
    end else begin
      if (we_i && addr_i == ADDR_WEN)  wen_q  <= wdata_i[NSRC-1:0];
      if (we_i && addr_i == ADDR_STAB) stab_q <= wdata_i[STAB_W-1:0];
      cause_q <= (cause_q & ~clr_vec) | set_vec;  // set wins over clear
    end
  end

  always_comb begin
    case (addr_i)
      ADDR_MODE:  rdata_o = DATA_W'(mode_i);
      ADDR_WEN:   rdata_o = DATA_W'(wen_q);
      ADDR_CAUSE: rdata_o = DATA_W'(cause_q);
      default:    rdata_o = DATA_W'(stab_q);
    endcase
  end

  assign wake_en_o  = wen_q;
  assign stab_o     = stab_q;
  assign mode_wr_o  = we_i && addr_i == ADDR_MODE;
  assign mode_req_o = wdata_i[1:0];

  assert_cause_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(cause_q) & ~$past(clr_vec)) & ~cause_q) == '0);
  assert_cause_needs_en_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cause_q & ~$past(cause_q)) & ~$past(wen_q)) == '0);
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_wake_pkg::*;
#(
  parameter int ENTRY_CYC = 4,
  parameter int STAB_W    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_mode_i,
  input  logic              wake_i,
  input  logic [STAB_W-1:0] stab_i,
  output logic [1:0]        mode_o,
  output logic              rec_en_o,
  output logic              core_pwr_en_o,
  output logic              core_rst_no,
  output logic              core_clk_en_o,
  output logic              dram_sr_o
);
  localparam logic [STAB_W-1:0] ENTRY_LAST = STAB_W'(ENTRY_CYC - 1);

  pstate_e           state_q, state_d;
  pmode_e            tgt_q, tgt_d;
  logic [STAB_W-1:0] cnt_q, cnt_d, stab_last;

  assign stab_last = (stab_i == '0) ? '0 : stab_i - 1'b1;

  always_comb begin
    state_d = state_q;
    tgt_d   = tgt_q;
    cnt_d   = cnt_q + 1'b1;
    case (state_q)
      ST_RUN: begin
        cnt_d = '0;
        if (req_valid_i && req_mode_i != MODE_FULL) begin
          state_d = ST_ENTER;
          tgt_d   = pmode_e'(req_mode_i);
        end
      end
      ST_ENTER: begin
        if (wake_i) begin
          state_d = ST_RUN;
          cnt_d   = '0;
        end else if (cnt_q == ENTRY_LAST) begin
          state_d = ST_LOW;
          cnt_d   = '0;
        end
      end
      ST_LOW: begin
        cnt_d = '0;
        if (wake_i) state_d = (tgt_q == MODE_HIB) ? ST_PWRUP : ST_RUN;
      end
      default: begin  // ST_PWRUP
        if (cnt_q >= stab_last) begin
          state_d = ST_RUN;
          cnt_d   = '0;
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PWRUP;  // always-on reset wakes unconditionally
      tgt_q   <= MODE_HIB;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      tgt_q   <= tgt_d;
      cnt_q   <= cnt_d;
    end
  end

  logic low_hib;
  assign low_hib = (state_q == ST_LOW) && (tgt_q == MODE_HIB);

  always_comb begin
    case (state_q)
      ST_LOW:   mode_o = tgt_q;
      ST_PWRUP: mode_o = MODE_HIB;
      default:  mode_o = MODE_FULL;
    endcase
  end

  assign rec_en_o      = (state_q == ST_ENTER) || (state_q == ST_LOW);
  assign core_clk_en_o = (state_q == ST_RUN) || (state_q == ST_ENTER);
  assign core_pwr_en_o = !low_hib;
  assign core_rst_no   = core_clk_en_o || ((state_q == ST_LOW) && !low_hib);
  assign dram_sr_o     = (state_q == ST_LOW) && (tgt_q == MODE_SUSP || tgt_q == MODE_HIB);

  assert_wake_to_full_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != $past(mode_o)) && ($past(mode_o) != MODE_FULL) |-> mode_o == MODE_FULL);
  assert_entry_from_full_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != $past(mode_o)) && (mode_o != MODE_FULL) |-> $past(mode_o) == MODE_FULL);
  assert_rst_hib_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !core_rst_no |-> mode_o == MODE_HIB);
  assert_hib_pwrup_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_hib && wake_i |=> core_pwr_en_o && !core_rst_no && mode_o == MODE_HIB);
  assert_entry_abort_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ENTER) && wake_i |=> core_clk_en_o && mode_o == MODE_FULL);
endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl
  import pwr_wake_pkg::*;
#(
  parameter int NGPIO     = 16,
  parameter int ENTRY_CYC = 4,
  parameter int STAB_W    = 16,
  parameter int STAB_RST  = 8,
  localparam int NSRC     = NFIXED + NGPIO,
  localparam int DATA_W   = (NSRC > STAB_W) ? NSRC : STAB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              carrier_ni,
  input  logic              pwr_btn_i,
  input  logic              rtc_alarm_i,
  input  logic [NGPIO-1:0]  gpio_i,
  input  logic              card_irq_ni,
  output logic [1:0]        mode_o,
  output logic              core_pwr_en_o,
  output logic              core_rst_no,
  output logic              core_clk_en_o,
  output logic              dram_sr_o
);
  logic [NSRC-1:0]   act, edges, wake_en;
  logic [STAB_W-1:0] stab;
  logic              mode_wr, rec_en, wake;
  logic [1:0]        mode_req;

  assign act  = {gpio_i, ~card_irq_ni, rtc_alarm_i, pwr_btn_i, ~carrier_ni};
  assign wake = |(edges & wake_en);

  pwr_wake_sync #(.N(NSRC)) u_sync (
    .clk_i, .rst_ni, .act_i(act), .edge_o(edges)
  );

  pwr_wake_regs #(.NSRC(NSRC), .STAB_W(STAB_W), .STAB_RST(STAB_RST), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .edge_i(edges), .rec_en_i(rec_en), .mode_i(mode_o),
    .wake_en_o(wake_en), .stab_o(stab), .mode_wr_o(mode_wr), .mode_req_o(mode_req)
  );

  pwr_mode_fsm #(.ENTRY_CYC(ENTRY_CYC), .STAB_W(STAB_W)) u_fsm (
    .clk_i, .rst_ni,
    .req_valid_i(mode_wr), .req_mode_i(mode_req), .wake_i(wake), .stab_i(stab),
    .mode_o, .rec_en_o(rec_en), .core_pwr_en_o, .core_rst_no, .core_clk_en_o, .dram_sr_o
  );
endmodule

// File: tb/pwr_wake_ctrl_bench.sv
module pwr_wake_ctrl_bench;
  localparam int NG = 16;
  localparam int DW = 20;
  localparam int STAB = 5;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic reg_we_i = 1'b0;
  logic [1:0] reg_addr_i = 2'd0;
  logic [DW-1:0] reg_wdata_i = '0, reg_rdata_o;
  logic carrier_ni = 1'b1, pwr_btn_i = 1'b0, rtc_alarm_i = 1'b0, card_irq_ni = 1'b1;
  logic [NG-1:0] gpio_i = '0;
  logic [1:0] mode_o;
  logic core_pwr_en_o, core_rst_no, core_clk_en_o, dram_sr_o;

  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  pwr_wake_ctrl u_pwr_wake_ctrl (.*);

  // {mode[1:0], enabled, src[4:0]}
  localparam logic [7:0] VEC [8] = '{
    {2'b01, 1'b1, 5'd0}, {2'b10, 1'b1, 5'd1}, {2'b11, 1'b1, 5'd2}, {2'b01, 1'b1, 5'd3},
    {2'b10, 1'b1, 5'd4}, {2'b11, 1'b1, 5'd19}, {2'b01, 1'b0, 5'd10}, {2'b11, 1'b0, 5'd3}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  task automatic drive(input int src, input logic a);
    case (src)
      0: carrier_ni = ~a;
      1: pwr_btn_i = a;
      2: rtc_alarm_i = a;
      3: card_irq_ni = ~a;
      default: gpio_i[src-4] = a;
    endcase
  endtask

  function automatic logic [3:0] outs_for(input logic [1:0] m);
    case (m)
      2'b00: return 4'b1110;
      2'b01: return 4'b0110;
      2'b10: return 4'b0111;
      default: return 4'b0001;
    endcase
  endfunction

  task automatic pulse(input int src);
    drive(src, 1'b1);
    repeat (3) @(negedge clk_i);
  endtask

  task automatic release_src(input int src);
    drive(src, 1'b0);
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    logic [DW-1:0] d;
    // reset
    repeat (3) @(negedge clk_i);
    check("R1 mode in reset", 32'(mode_o), 32'h3);
    check("R1 pwr/rst in reset", {30'b0, core_pwr_en_o, core_rst_no}, 32'b10);
    rst_ni = 1'b1;
    repeat (7) @(negedge clk_i);
    check("R1 held 7 edges", {29'b0, mode_o, core_rst_no}, {29'b0, 2'b11, 1'b0});
    @(negedge clk_i);
    check("R1 woke on 8th edge", {29'b0, mode_o, core_rst_no}, {29'b0, 2'b00, 1'b1});
    rd(2'd1, d); check("R1 enables reset", 32'(d), 0);
    rd(2'd2, d); check("R1 causes reset", 32'(d), 0);
    rd(2'd3, d); check("R1 stab reset", 32'(d), 8);
    check("R4 fullspeed outputs", 32'({core_clk_en_o, core_pwr_en_o, core_rst_no, dram_sr_o}), 32'hE);

    wr(2'd3, DW'(STAB));

    // vector table
    for (int i = 0; i < 8; i++) begin
      logic [1:0] m;
      logic en;
      int src;
      m = VEC[i][7:6]; en = VEC[i][5]; src = int'(VEC[i][4:0]);
      wr(2'd1, en ? DW'(1 << src) : ~DW'(1 << src));
      wr(2'd2, '1);
      wr(2'd0, DW'(m));
      repeat (3) @(negedge clk_i);
      check("R2 entry window", 32'(mode_o), 0);
      @(negedge clk_i);
      check("R2 mode entered", 32'(mode_o), 32'(m));
      check("R4 low outputs", 32'({core_clk_en_o, core_pwr_en_o, core_rst_no, dram_sr_o}), 32'(outs_for(m)));
      pulse(src);
      if (en) begin
        if (m == 2'b11) begin
          check("R7 hib pwrup", {29'b0, mode_o, core_pwr_en_o, core_rst_no}, {28'b0, 4'b1110});
          repeat (STAB - 1) @(negedge clk_i);
          check("R7 still in pwrup", 32'(core_rst_no), 0);
          @(negedge clk_i);
        end
        check("R5 woke to full", 32'(mode_o), 0);
        rd(2'd2, d); check("R8 cause recorded", 32'(d), 32'(1 << src));
        release_src(src);
      end else begin
        check("R6 disabled no wake", 32'(mode_o), 32'(m));
        rd(2'd2, d); check("R6 disabled no cause", 32'(d), 0);
        release_src(src);
        pulse(1);
        if (m == 2'b11) repeat (STAB) @(negedge clk_i);
        check("R5 recovery", 32'(mode_o), 0);
        release_src(1);
      end
    end

    // R8 sticky, W1C of single bit, no record in fullspeed
    rd(2'd2, d); check("R8 sticky", 32'(d), 32'h2);
    wr(2'd2, DW'(32'h4));
    rd(2'd2, d); check("R8 other bit clear no effect", 32'(d), 32'h2);
    wr(2'd2, DW'(32'h2));
    rd(2'd2, d); check("R8 w1c", 32'(d), 0);
    wr(2'd1, '1);
    pulse(7);
    rd(2'd2, d); check("R8 no record in full", 32'(d), 0);
    release_src(7);

    // R3 requests outside fullspeed / of 00
    wr(2'd0, DW'(0));
    repeat (6) @(negedge clk_i);
    check("R3 write 00 no effect", {30'b0, mode_o}, 0);
    check("R3 clk stays on", 32'(core_clk_en_o), 1);
    wr(2'd0, DW'(1));
    repeat (4) @(negedge clk_i);
    wr(2'd0, DW'(3));
    repeat (6) @(negedge clk_i);
    check("R3 low-mode request ignored", 32'(mode_o), 1);

    // R10 held level not a wake
    drive(1, 1'b1);   // button already held in standby: edge at standby wakes
    repeat (3) @(negedge clk_i);
    check("R5 wake by button", 32'(mode_o), 0);
    wr(2'd0, DW'(2));
    repeat (10) @(negedge clk_i);
    check("R10 held level no wake", 32'(mode_o), 2);
    release_src(1);
    check("R10 release no wake", 32'(mode_o), 2);
    pulse(6);
    check("R10 fresh edge wakes", 32'(mode_o), 0);
    release_src(6);

    // R9 abort during entry
    wr(2'd2, '1);
    wr(2'd0, DW'(3));
    drive(9, 1'b1);
    repeat (3) @(negedge clk_i);
    check("R9 aborted", 32'(mode_o), 0);
    repeat (6) @(negedge clk_i);
    check("R9 stays full", {30'b0, core_clk_en_o, core_pwr_en_o}, 32'b11);
    check("R9 mode full", 32'(mode_o), 0);
    rd(2'd2, d); check("R9 cause recorded", 32'(d), 32'(1 << 9));
    release_src(9);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule